// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Flag

This block is the integer execute stage of a three-operand RISC core. It takes two 32-bit operands, a 5-bit shift amount and a 5-bit operation code. It returns a 32-bit result and a flag that marks two's-complement overflow. The block is purely combinational, so both outputs follow the inputs in the same cycle.

The operations are:
- add and subtract, each in a trapping form and a non-trapping form;
- the four bitwise operations;
- signed and unsigned less-than compares;
- placing an immediate in the upper half of the word;
- shifts left, right-logical and right-arithmetic, with the count taken either from the shift-amount input or from operand A.

The immediate has already been extended before it reaches operand B. The flag only reports overflow; taking the trap is left to the pipeline control.

Top module: `alu_core`

## Requirements
- R1: Codes 0 (ADD), 1 (ADDU), 2 (SUB) and 3 (SUBU) return A+B or A-B modulo 2^32. The result is combinational and valid without any clock edge.
- R2: ADD and SUB set `ovf` to 1 exactly when the two's-complement result does not fit in 32 bits.
- R3: `ovf` is 0 for ADDU, SUBU and every code other than 0 and 2.
- R4: Code 4 returns A AND B, code 5 returns A OR B, code 6 returns A XOR B, and code 7 returns NOT (A OR B).
- R5: Code 8 (SLT) returns 1 when A < B as two's-complement numbers, and 0 otherwise.
- R6: Code 9 (SLTU) returns 1 when A < B as unsigned numbers, and 0 otherwise. With A = all ones and B = 1, SLT gives 1 and SLTU gives 0.
- R7: Code 10 (LUI) returns B[15:0] in bits 31:16 and zero in bits 15:0.
- R8: Code 11 shifts B left and code 12 shifts B right, both by `shamt` and both filling with zeros.
- R9: Code 13 shifts B right by `shamt` and fills the vacated bits with B[31].
- R10: Codes 14, 15 and 16 shift B left, right-logical and right-arithmetic by A[4:0]. The upper bits of A and the `shamt` input have no effect on these codes.
- R11: Codes 17 to 31 return a result of 0 with `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; also the shift count for the variable shifts |
| opnd_b | input | 32 | Second operand; the value that is shifted; the source of the immediate for LUI |
| shamt | input | 5 | Constant shift count |
| op_sel | input | 5 | Operation code |
| result | output | 32 | Result |
| ovf | output | 1 | Signed overflow for ADD and SUB |

## Verification
Add and subtract are driven with operands chosen to tell the trapping forms from the non-trapping ones:
- the largest positive value plus one, and the most negative value minus one, where only the signed forms may flag;
- mixed-sign sums that wrap to zero without overflow;
- an unsigned borrow.

The compares use the all-ones/one pair and the most-negative/largest-positive pair, where the signed and unsigned answers disagree, and also equal operands. Shifts use counts 0, 4 and 31 on values whose sign bit is set or clear, which separates zero fill from sign fill. The variable shifts put junk in the upper bits of A and in `shamt` to show that only A[4:0] counts.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_LUI  = 5'd10,
    OP_SLL  = 5'd11,
    OP_SRL  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLLV = 5'd14,
    OP_SRLV = 5'd15,
    OP_SRAV = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W:0]   wide;
  logic [W-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + (W+1)'(sub);
  assign sum   = wide[W-1:0];
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  assign lt_s  = sum[W-1] ^ ovf;
  assign lt_u  = ~wide[W];

  logic signed [W:0] sext_ref;
  always_comb begin
    sext_ref = sub ? ($signed({a[W-1], a}) - $signed({b[W-1], b}))
                   : ($signed({a[W-1], a}) + $signed({b[W-1], b}));
    // R2
    ovf_wide_chk: assert (ovf == (sext_ref[W] != sext_ref[W-1]));
    // R6
    if (sub) ltu_cmp_chk: assert (lt_u == (a < b));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  alu_pkg::logic_fn_e fn,
  output logic [W-1:0]       y
);
  import alu_pkg::*;
  always_comb begin
    unique case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]         val,
  input  logic [SHW-1:0]       amt,
  input  alu_pkg::shift_kind_e kind,
  output logic [W-1:0]         y
);
  import alu_pkg::*;
  always_comb begin
    case (kind)
      SH_LEFT: y = val << amt;
      SH_RLOG: y = val >> amt;
      default: y = W'($signed(val) >>> amt);
    endcase
  end

  always_comb begin
    // R9
    if (kind == SH_RARI && amt != '0) sra_fill_chk: assert (y[W-1] == val[W-1]);
    // R8
    if (kind == SH_RLOG && amt != '0) srl_zero_chk: assert (y[W-1] == 1'b0);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [SHW-1:0] shamt,
  input  logic [4:0]     op_sel,
  output logic [W-1:0]   result,
  output logic           ovf
);
  import alu_pkg::*;
  localparam int HALF = W / 2;

  alu_op_e     op;
  logic        do_sub, as_ovf, lt_s, lt_u;
  logic [W-1:0] as_sum, lg_y, sh_y;
  logic_fn_e   lg_fn;
  shift_kind_e sh_kind;
  logic [SHW-1:0] sh_amt;
  logic        var_shift;

  assign op = alu_op_e'(op_sel);

  // Compares always subtract; only ADD/ADDU add.
  assign do_sub = !(op == OP_ADD || op == OP_ADDU);

  alu_addsub #(.W(W)) u_as (
    .a(opnd_a), .b(opnd_b), .sub(do_sub),
    .sum(as_sum), .ovf(as_ovf), .lt_s(lt_s), .lt_u(lt_u)
  );

  assign lg_fn = logic_fn_e'(op_sel[1:0]);
  alu_logic #(.W(W)) u_lg (.a(opnd_a), .b(opnd_b), .fn(lg_fn), .y(lg_y));

  assign var_shift = (op == OP_SLLV || op == OP_SRLV || op == OP_SRAV);
  assign sh_amt    = var_shift ? opnd_a[SHW-1:0] : shamt;
  always_comb begin
    case (op)
      OP_SRL, OP_SRLV: sh_kind = SH_RLOG;
      OP_SRA, OP_SRAV: sh_kind = SH_RARI;
      default:         sh_kind = SH_LEFT;
    endcase
  end
  alu_shift #(.W(W), .SHW(SHW)) u_sh (
    .val(opnd_b), .amt(sh_amt), .kind(sh_kind), .y(sh_y)
  );

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin result = as_sum; ovf = as_ovf; end
      OP_ADDU, OP_SUBU: result = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR: result = lg_y;
      OP_SLT:  result = W'(lt_s);
      OP_SLTU: result = W'(lt_u);
      OP_LUI:  result = {opnd_b[HALF-1:0], {(W-HALF){1'b0}}};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: result = sh_y;
      default: ;
    endcase
  end

  always_comb begin
    // R3
    if (!(op_sel == 5'd0 || op_sel == 5'd2)) ovf_gate_chk: assert (!ovf);
    // R5
    if (op_sel == 5'd8 || op_sel == 5'd9) slt_bool_chk: assert (result[W-1:1] == '0);
    // R7
    if (op_sel == 5'd10) lui_low_chk: assert (result[HALF-1:0] == '0);
    // R11
    if (op_sel > 5'd16) unused_zero_chk: assert (result == '0);
  end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a, b, res;
  logic [4:0]  sh, op;
  logic        ovf;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  alu_core u0 (.opnd_a(a), .opnd_b(b), .shamt(sh), .op_sel(op), .result(res), .ovf(ovf));

  task automatic run(input string tag, input logic [4:0] o, input logic [31:0] va,
                     input logic [31:0] vb, input logic [4:0] vs,
                     input logic [31:0] er, input logic eo);
    @(negedge clk);
    op = o; a = va; b = vb; sh = vs;
    #1;
    total++;
    if (res !== er || ovf !== eo) begin
      bad++;
      $display("FAIL %s op=%0d: result=%h ovf=%b expected result=%h ovf=%b",
               tag, o, res, ovf, er, eo);
    end
  endtask

  task automatic t_reset;
    run("R1 reset idle", 5'd0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_addsub;
    run("R1 add",  5'd0, 32'd5,  32'd7, 5'd0, 32'd12, 1'b0);
    run("R1 sub",  5'd2, 32'd10, 32'd3, 5'd0, 32'd7,  1'b0);
    run("R1 subu borrow", 5'd3, 32'd3, 32'd5, 5'd0, 32'hFFFF_FFFE, 1'b0);
    run("R2 add wrap no ovf", 5'd0, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_overflow;
    run("R2 add ovf", 5'd0, 32'h7FFF_FFFF, 32'd1, 5'd0, 32'h8000_0000, 1'b1);
    run("R2 sub ovf", 5'd2, 32'h8000_0000, 32'd1, 5'd0, 32'h7FFF_FFFF, 1'b1);
    run("R3 addu no ovf", 5'd1, 32'h7FFF_FFFF, 32'd1, 5'd0, 32'h8000_0000, 1'b0);
    run("R3 subu no ovf", 5'd3, 32'h8000_0000, 32'd1, 5'd0, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_logic;
    run("R4 and", 5'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'h00F0_1200, 1'b0);
    run("R4 or",  5'd5, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'hFFF0_FF34, 1'b0);
    run("R4 xor", 5'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'hFF00_ED34, 1'b0);
    run("R4 nor", 5'd7, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'h000F_00CB, 1'b0);
  endtask

  task automatic t_compare;
    run("R5 slt ones<1",  5'd8, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd1, 1'b0);
    run("R6 sltu ones<1", 5'd9, 32'hFFFF_FFFF, 32'd1, 5'd0, 32'd0, 1'b0);
    run("R5 slt 2<1",     5'd8, 32'd2, 32'd1, 5'd0, 32'd0, 1'b0);
    run("R5 slt equal",   5'd8, 32'd9, 32'd9, 5'd0, 32'd0, 1'b0);
    run("R5 slt minneg<maxpos", 5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd1, 1'b0);
    run("R6 sltu minneg<maxpos", 5'd9, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd0, 1'b0);
    run("R6 sltu 1<ones", 5'd9, 32'd1, 32'hFFFF_FFFF, 5'd0, 32'd1, 1'b0);
  endtask

  task automatic t_lui;
    run("R7 lui", 5'd10, 32'h1234_5678, 32'hDEAD_BEEF, 5'd7, 32'hBEEF_0000, 1'b0);
  endtask

  task automatic t_const_shift;
    run("R8 sll 31", 5'd11, 32'd0, 32'd1, 5'd31, 32'h8000_0000, 1'b0);
    run("R8 srl 4",  5'd12, 32'd0, 32'h8000_0000, 5'd4, 32'h0800_0000, 1'b0);
    run("R8 sll 0",  5'd11, 32'd0, 32'hA5A5_0001, 5'd0, 32'hA5A5_0001, 1'b0);
  endtask

  task automatic t_sra;
    run("R9 sra neg 4",  5'd13, 32'd0, 32'h8000_0000, 5'd4,  32'hF800_0000, 1'b0);
    run("R9 sra pos 4",  5'd13, 32'd0, 32'h4000_0000, 5'd4,  32'h0400_0000, 1'b0);
    run("R9 sra neg 31", 5'd13, 32'd0, 32'h8000_0000, 5'd31, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_var_shift;
    run("R10 sllv", 5'd14, 32'h0000_0024, 32'd1, 5'd9, 32'h10, 1'b0);
    run("R10 sllv upper A ignored", 5'd14, 32'hFFFF_FFE4, 32'd1, 5'd0, 32'h10, 1'b0);
    run("R10 srlv", 5'd15, 32'h0000_0021, 32'h8000_0000, 5'd3, 32'h4000_0000, 1'b0);
    run("R10 srav", 5'd16, 32'h0000_003F, 32'h8000_0000, 5'd0, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_unused;
    run("R11 code 17", 5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 32'h0, 1'b0);
    run("R11 code 31", 5'd31, 32'h7FFF_FFFF, 32'd1, 5'd1, 32'h0, 1'b0);
  endtask

  initial begin
    op = '0; a = '0; b = '0; sh = '0;
    t_reset();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_addsub();
    t_overflow();
    t_logic();
    t_compare();
    t_lui();
    t_const_shift();
    t_sra();
    t_var_shift();
    t_unused();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule